// File: doc/BRIEF.md
# Strap Capture and Power-Down Sequencer

This block sits beside the synthesizer core of a system clock generator. During power-on, a small set of shared pins act as inputs: their levels choose the startup frequency code and one option bit. A dual-role input first serves as the power-good strobe. On its first synchronized rising edge the block captures the strap levels and turns the shared pins into clock outputs. From then on the same input is an asynchronous, active-low power-down request.

When power-down is requested, the block synchronizes the request. It stops the CPU, PCI and 48 MHz clock enables low on the next falling edge of the internal CPU clock, which is modelled as a divide-by-two phase of `clk`. It lets the reference clock drain for a few more cycles. Only after every clock is low does it drop the VCO and crystal run enables. On release it restarts the oscillators and holds every clock low for a programmable settling interval, which stands in for the 4 ms restart limit. It also selects the active frequency code, taken either from the captured straps or from a register field, and it applies a global tristate control.

Top module: `strap_pdn_seq`

## Requirements
- R1: After reset the shared pins are inputs (`pin_oe`=0), all four clock enables are low, `vco_en` and `xtal_en` are high, and `strap_rb` is all zeros (the stored image of pulled-up pins).
- R2: On the first synchronized rise of `pg_pdn_n`, `strap_pin` is captured and held in `strap_rb` bit-inverted (bits [3:0] frequency select, bit 4 option). `pin_oe` then goes high. Later changes on `strap_pin`, and later rises of `pg_pdn_n`, leave `strap_rb` unchanged.
- R3: While `pg_pdn_n` stays low before the capture, nothing changes: the clock enables stay low, the oscillators run and no strap value is stored.
- R4: With `cfg_use_reg`=0, `freq_code` equals the captured pin levels (the inverse of `strap_rb[3:0]`). With `cfg_use_reg`=1, it equals `cfg_reg_code`.
- R5: `cfg_tristate`=1 drives `out_hiz` high and forces `pin_oe` low.
- R6: In normal running, `ref_en` and `usb_en` are high. `cpu_en` follows the synchronized `cpu_stop_n`, and `pci_en` follows the synchronized `pci_stop_n`.
- R7: After `pg_pdn_n` falls, `cpu_en`, `pci_en` and `usb_en` go low together on an internal CPU clock falling edge, 4 or 5 cycles after the input changed.
- R8: `ref_en` stays high for REF_DRAIN cycles after the other enables fall. `vco_en` and `xtal_en` fall one cycle after `ref_en`, never while any clock enable is high.
- R9: While powered down, `cpu_stop_n` and `pci_stop_n` have no effect on any output.
- R10: When `pg_pdn_n` rises after a power-down, the oscillators restart at once. The clock enables stay low until exactly WAKE_CYC+3 cycles after the input rose, and the straps are not captured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Power-on reset, active low |
| pg_pdn_n | input | 1 | Power-good strobe, later power-down request (active low) |
| strap_pin | input | NSTRAP | Strap levels on shared pins |
| cpu_stop_n | input | 1 | Asynchronous CPU clock stop, active low |
| pci_stop_n | input | 1 | Asynchronous PCI clock stop, active low |
| cfg_use_reg | input | 1 | 1: frequency code from register field |
| cfg_reg_code | input | NFS | Register-programmed frequency code |
| cfg_tristate | input | 1 | Tristate all outputs |
| freq_code | output | NFS | Active frequency code |
| strap_rb | output | NSTRAP | Captured straps, inverted |
| pin_oe | output | 1 | Shared pins driven as outputs |
| out_hiz | output | 1 | All outputs high impedance |
| cpu_en | output | 1 | CPU clock enable |
| pci_en | output | 1 | PCI clock enable |
| ref_en | output | 1 | Reference clock enable |
| usb_en | output | 1 | 48 MHz clock enable |
| vco_en | output | 1 | VCO run enable |
| xtal_en | output | 1 | Crystal oscillator run enable |

## Verification
A wrong sequencer state shows up as the enable vector `{pin_oe, cpu_en, pci_en, ref_en, usb_en, vco_en, xtal_en}` taking a value out of its fixed order. Examples are the oscillators dropping while the reference clock still runs, or an extra step appearing. The scoreboard catches this on the first cycle the vector changes. A bad settling counter or a missed synchronizer stage shifts the power-down and wake latencies, which are checked to the cycle. A capture fault shows up in `strap_rb` and `freq_code` right after the power-good rise, or when the straps move later on.

// File: rtl/strap_pdn_pkg.sv
package strap_pdn_pkg;

  typedef enum logic [2:0] {
    PS_WAIT_PG   = 3'd0,
    PS_RUN       = 3'd1,
    PS_CLKSTOP   = 3'd2,
    PS_REFDRAIN  = 3'd3,
    PS_OSCOFF    = 3'd4,
    PS_RESTART   = 3'd5
  } pstate_t;

  typedef struct packed {
    logic cpu;
    logic pci;
    logic refc;
    logic usb;
  } clk_en_t;

endpackage

// File: rtl/psq_sync.sv
module psq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/psq_strap_latch.sv
module psq_strap_latch #(
  parameter int NFS  = 4,
  parameter int NOPT = 1,
  localparam int NSTRAP = NFS + NOPT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [NSTRAP-1:0] strap_pin,
  input  logic              cfg_use_reg,
  input  logic [NFS-1:0]    cfg_reg_code,
  output logic [NSTRAP-1:0] strap_rb,
  output logic [NFS-1:0]    freq_code,
  output logic              strap_done
);
  // stored image is the complement of the pin level
  function automatic logic [NSTRAP-1:0] to_stored(input logic [NSTRAP-1:0] lvl);
    return ~lvl;
  endfunction

  function automatic logic [NFS-1:0] to_level(input logic [NFS-1:0] stored);
    return ~stored;
  endfunction

  logic [NSTRAP-1:0] strap_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= '0;
      done_q  <= 1'b0;
    end else if (capture && !done_q) begin
      strap_q <= to_stored(strap_pin);
      done_q  <= 1'b1;
    end
  end

  assign strap_rb   = strap_q;
  assign strap_done = done_q;
  assign freq_code  = cfg_use_reg ? cfg_reg_code : to_level(strap_q[NFS-1:0]);
endmodule

// File: rtl/psq_pdn_fsm.sv
module psq_pdn_fsm
  import strap_pdn_pkg::*;
#(
  parameter int REF_DRAIN = 3,
  parameter int WAKE_CYC  = 533334,
  localparam int CMAX = (REF_DRAIN > WAKE_CYC) ? REF_DRAIN : WAKE_CYC,
  localparam int CW   = $clog2(CMAX + 1)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pin_s,
  input  logic    cpu_ok,
  input  logic    pci_ok,
  output logic    capture,
  output logic    pd_active,
  output logic    int_ph,
  output clk_en_t en,
  output logic    osc_on
);
  pstate_t       st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          ph, pin_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PS_WAIT_PG;
      cnt      <= '0;
      ph       <= 1'b0;
      pin_prev <= 1'b0;
    end else begin
      st       <= st_nx;
      cnt      <= cnt_nx;
      ph       <= ~ph;
      pin_prev <= pin_s;
    end
  end

  always_comb begin
    st_nx   = st;
    cnt_nx  = cnt;
    capture = 1'b0;
    unique case (st)
      PS_WAIT_PG: if (pin_s && !pin_prev) begin
        capture = 1'b1;
        st_nx   = PS_RUN;
      end
      PS_RUN: if (!pin_s) st_nx = PS_CLKSTOP;
      PS_CLKSTOP: if (ph) begin
        st_nx  = PS_REFDRAIN;
        cnt_nx = CW'(REF_DRAIN);
      end
      PS_REFDRAIN: if (cnt == '0) st_nx = PS_OSCOFF;
                   else cnt_nx = cnt - 1'b1;
      PS_OSCOFF: if (pin_s) begin
        st_nx  = PS_RESTART;
        cnt_nx = CW'(WAKE_CYC - 1);
      end
      PS_RESTART: if (cnt == '0) st_nx = PS_RUN;
                  else cnt_nx = cnt - 1'b1;
      default: st_nx = PS_WAIT_PG;
    endcase
  end

  logic running;
  assign running   = (st == PS_RUN) || (st == PS_CLKSTOP);
  assign en.cpu    = running && cpu_ok;
  assign en.pci    = running && pci_ok;
  assign en.usb    = running;
  assign en.refc   = running || ((st == PS_REFDRAIN) && (cnt != '0));
  assign osc_on    = (st != PS_OSCOFF);
  assign pd_active = (st == PS_REFDRAIN) || (st == PS_OSCOFF) || (st == PS_RESTART);
  assign int_ph    = ph;
endmodule

// File: rtl/strap_pdn_seq.sv
module strap_pdn_seq
  import strap_pdn_pkg::*;
#(
  parameter int NFS       = 4,
  parameter int NOPT      = 1,
  parameter int SYNC_STG  = 2,
  parameter int REF_DRAIN = 3,
  parameter int WAKE_CYC  = 533334,
  localparam int NSTRAP   = NFS + NOPT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_pdn_n,
  input  logic [NSTRAP-1:0] strap_pin,
  input  logic              cpu_stop_n,
  input  logic              pci_stop_n,
  input  logic              cfg_use_reg,
  input  logic [NFS-1:0]    cfg_reg_code,
  input  logic              cfg_tristate,
  output logic [NFS-1:0]    freq_code,
  output logic [NSTRAP-1:0] strap_rb,
  output logic              pin_oe,
  output logic              out_hiz,
  output logic              cpu_en,
  output logic              pci_en,
  output logic              ref_en,
  output logic              usb_en,
  output logic              vco_en,
  output logic              xtal_en
);
  logic [2:0] async_in, async_s;
  logic       capture, strap_done, pd_active, int_ph, osc_on;
  clk_en_t    en;

  assign async_in = {pg_pdn_n, cpu_stop_n, pci_stop_n};

  psq_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(async_s)
  );

  psq_pdn_fsm #(.REF_DRAIN(REF_DRAIN), .WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pin_s(async_s[2]),
    .cpu_ok(async_s[1]), .pci_ok(async_s[0]),
    .capture(capture), .pd_active(pd_active), .int_ph(int_ph),
    .en(en), .osc_on(osc_on)
  );

  psq_strap_latch #(.NFS(NFS), .NOPT(NOPT)) u_strap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .strap_pin(strap_pin),
    .cfg_use_reg(cfg_use_reg), .cfg_reg_code(cfg_reg_code),
    .strap_rb(strap_rb), .freq_code(freq_code), .strap_done(strap_done)
  );

  assign pin_oe  = strap_done && !cfg_tristate;
  assign out_hiz = cfg_tristate;
  assign cpu_en  = en.cpu;
  assign pci_en  = en.pci;
  assign ref_en  = en.refc;
  assign usb_en  = en.usb;
  assign vco_en  = osc_on;
  assign xtal_en = osc_on;
endmodule

// File: rtl/strap_pdn_seq_chk.sv
module strap_pdn_seq_chk #(
  parameter int NFS = 4,
  parameter int NSTRAP = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_use_reg,
  input logic [NFS-1:0]    freq_code,
  input logic [NSTRAP-1:0] strap_rb,
  input logic              pin_oe,
  input logic              out_hiz,
  input logic              cpu_en,
  input logic              pci_en,
  input logic              ref_en,
  input logic              usb_en,
  input logic              vco_en,
  input logic              strap_done,
  input logic              pd_active,
  input logic              int_ph
);
  assert_oe_after_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> strap_done);
  assert_rb_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strap_done) |-> $stable(strap_rb));
  assert_quiet_before_pg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_done |-> (!cpu_en && !pci_en && !ref_en && !usb_en && vco_en));
  assert_code_from_strap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && !cfg_use_reg) |-> (freq_code == ~strap_rb[NFS-1:0]));
  assert_hiz_no_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz |-> !pin_oe);
  assert_stop_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(usb_en) |-> $past(int_ph));
  assert_osc_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vco_en |-> !(cpu_en || pci_en || ref_en || usb_en));
  assert_ref_before_osc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vco_en) |-> $past(!ref_en));
  assert_pd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> (!cpu_en && !pci_en));
endmodule

bind strap_pdn_seq strap_pdn_seq_chk #(.NFS(NFS), .NSTRAP(NSTRAP)) u_chk (.*);

// File: tb/strap_pdn_seq_test.sv
module strap_pdn_seq_test;
  localparam int NFS = 4;
  localparam int NSTRAP = 5;
  localparam int REF_DRAIN = 3;
  localparam int WAKE = 40;

  logic clk = 1'b0;
  logic rst_n, pg_pdn_n, cpu_stop_n, pci_stop_n, cfg_use_reg, cfg_tristate;
  logic [NSTRAP-1:0] strap_pin, strap_rb;
  logic [NFS-1:0] cfg_reg_code, freq_code;
  logic pin_oe, out_hiz, cpu_en, pci_en, ref_en, usb_en, vco_en, xtal_en;

  always #2 clk = ~clk;

  strap_pdn_seq #(.NFS(NFS), .NOPT(1), .SYNC_STG(2), .REF_DRAIN(REF_DRAIN),
                  .WAKE_CYC(WAKE)) uut (
    .clk(clk), .rst_n(rst_n), .pg_pdn_n(pg_pdn_n), .strap_pin(strap_pin),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .cfg_use_reg(cfg_use_reg),
    .cfg_reg_code(cfg_reg_code), .cfg_tristate(cfg_tristate),
    .freq_code(freq_code), .strap_rb(strap_rb), .pin_oe(pin_oe), .out_hiz(out_hiz),
    .cpu_en(cpu_en), .pci_en(pci_en), .ref_en(ref_en), .usb_en(usb_en),
    .vco_en(vco_en), .xtal_en(xtal_en)
  );

  int n_chk = 0, n_fail = 0;
  bit mon_on = 0, finished = 0;
  logic [6:0] exp_q[$];
  logic [6:0] mon_prev;
  wire  [6:0] vec = {pin_oe, cpu_en, pci_en, ref_en, usb_en, vco_en, xtal_en};

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_vec(input logic [6:0] v);
    exp_q.push_back(v);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: every change of the enable vector must match the next expected item
  always @(negedge clk) begin
    if (mon_on && vec !== mon_prev) begin
      if (exp_q.size() == 0) check(1'b0, "R8 order (unexpected change)", 32'(vec), 32'(mon_prev));
      else begin
        logic [6:0] e;
        e = exp_q.pop_front();
        check(vec === e, "R8 sequence", 32'(vec), 32'(e));
      end
      mon_prev = vec;
    end
  end

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int n;
    rst_n = 0; pg_pdn_n = 0; strap_pin = 5'b11010; cpu_stop_n = 1; pci_stop_n = 1;
    cfg_use_reg = 0; cfg_reg_code = '0; cfg_tristate = 0;
    step(3); rst_n = 1; step(1);
    check(vec === 7'b0000011, "R1 reset vector", 32'(vec), 32'h03);
    check(strap_rb === 5'b00000, "R1 reset strap_rb", 32'(strap_rb), 0);
    mon_prev = vec; mon_on = 1;

    // R3: pin held low before capture
    step(12);
    check(vec === 7'b0000011, "R3 no change while low", 32'(vec), 32'h03);
    check(strap_rb === 5'b00000, "R3 nothing stored", 32'(strap_rb), 0);

    // R2: capture on power-good rise
    expect_vec(7'b1111111);
    pg_pdn_n = 1; step(6);
    check(strap_rb === 5'b00101, "R2 inverted capture", 32'(strap_rb), 32'h05);
    check(freq_code === 4'b1010, "R4 strap code", 32'(freq_code), 32'hA);
    strap_pin = 5'b00000; step(3);
    check(strap_rb === 5'b00101, "R2 later straps ignored", 32'(strap_rb), 32'h05);

    // R4: code source selection
    cfg_reg_code = 4'b0111; cfg_use_reg = 1; step(1);
    check(freq_code === 4'b0111, "R4 register code", 32'(freq_code), 32'h7);
    cfg_use_reg = 0; step(1);
    check(freq_code === 4'b1010, "R4 back to strap code", 32'(freq_code), 32'hA);

    // R5: tristate
    expect_vec(7'b0111111);
    cfg_tristate = 1; step(2);
    check(out_hiz === 1'b1, "R5 out_hiz", 32'(out_hiz), 1);
    expect_vec(7'b1111111);
    cfg_tristate = 0; step(2);

    // R6: stop inputs while running
    expect_vec(7'b1011111);
    cpu_stop_n = 0; step(4);
    check(cpu_en === 0 && pci_en === 1, "R6 cpu stop", 32'({cpu_en, pci_en}), 32'h1);
    expect_vec(7'b1111111);
    cpu_stop_n = 1; step(4);
    expect_vec(7'b1101111);
    pci_stop_n = 0; step(4);
    check(pci_en === 0 && cpu_en === 1, "R6 pci stop", 32'({cpu_en, pci_en}), 32'h2);
    expect_vec(7'b1111111);
    pci_stop_n = 1; step(4);

    // R7 / R8: power-down entry
    expect_vec(7'b1001011);
    expect_vec(7'b1000011);
    expect_vec(7'b1000000);
    pg_pdn_n = 0;
    n = 0;
    do begin step(1); n++; end while (cpu_en !== 0 && n < 20);
    check(n >= 4 && n <= 5, "R7 stop latency", 32'(n), 32'd4);
    check(usb_en === 0 && pci_en === 0 && ref_en === 1, "R7 enables low, ref draining",
          32'({usb_en, pci_en, ref_en}), 32'h1);
    n = 0;
    do begin step(1); n++; end while (ref_en !== 0 && n < 20);
    check(n == REF_DRAIN, "R8 ref drain cycles", 32'(n), 32'(REF_DRAIN));
    check(vco_en === 1, "R8 osc still on when ref stops", 32'(vco_en), 1);
    step(1);
    check(vco_en === 0 && xtal_en === 0, "R8 osc off after clocks", 32'({vco_en, xtal_en}), 0);

    // R9: stop inputs ignored while down
    cpu_stop_n = 0; pci_stop_n = 0; step(5);
    cpu_stop_n = 1; pci_stop_n = 1; step(5);
    check(vec === 7'b1000000, "R9 stops ignored", 32'(vec), 32'h40);

    // R10: wake-up
    expect_vec(7'b1000011);
    expect_vec(7'b1111111);
    pg_pdn_n = 1;
    n = 0;
    do begin step(1); n++; end while (cpu_en !== 1 && n < WAKE + 40);
    check(n == WAKE + 3, "R10 wake latency", 32'(n), 32'(WAKE + 3));
    check(strap_rb === 5'b00101, "R10 no recapture", 32'(strap_rb), 32'h05);

    step(4);
    check(exp_q.size() == 0, "R8 all expected steps seen", 32'(exp_q.size()), 0);
    report();
  end
endmodule